// File: doc/BRIEF.md
# Serial Command Receiver with Auto-Increment

This block is the host-side write port of a display controller. The host drives three wires: an active-low select (`selN`), a shift clock (`sclk`) and a data line (`sdata`). All three are brought into the system clock domain through synchroniser stages. A rising edge of the synchronised shift clock shifts one bit into an 8-bit word, least significant bit first. The block raises its own load strobe when the eighth bit arrives, so the host never sends a latch signal.

Each falling edge of select starts a new window, and bit framing restarts from that point. The first complete byte of a window is a command. Its upper three bits are an opcode and its lower five bits are a start address or a register value. For a RAM opcode, each later byte in the window becomes one write strobe to that RAM. The address steps up by one after each write and wraps at the RAM's depth. The other opcodes load the digit count, the brightness level or the all-lights mode.

Top module: `disp_cmd_receiver`

## Requirements
- R1: Bits on `sdata` are taken on rising edges of `sclk` while `selN` is low. They are assembled least significant bit first, so the first bit sent becomes bit 0 of the byte.
- R2: Each high-to-low change of `selN` restarts the bit count. A partial word left when `selN` rises produces no strobe and no register change. `sclk` edges while `selN` is high have no effect.
- R3: The first byte of a window is a command with the opcode in bits 7:5. 000 selects the character RAM (`charWe`), 001 the pattern RAM (`patWe`) and 010 the auxiliary RAM (`auxWe`). Bits 4:0 give the start address.
- R4: Each following byte in the same window gives exactly one write strobe to the selected RAM. The strobe carries that byte on `ramData` and the current pointer on `ramAddr`, and the pointer then increments.
- R5: The start address and every increment are reduced modulo the depth of the selected RAM: 16 for the character RAM, 32 for the pattern RAM and 16 for the auxiliary RAM.
- R6: Opcode 011 loads `digitCount` from bits 3:0, and a value of 0 means 16 digits.
- R7: Opcode 100 loads `brightness` from bits 4:0, capped at 16.
- R8: Opcode 101 loads `lightsMode` from bits 1:0. 0 is normal, 1 is all lit and 2 is all dark; code 3 is stored as 0.
- R9: While `rstN` is low, `digitCount` is 16, `brightness` is 0, `lightsMode` is 0, `ramAddr` is 0, `ramData` is 0 and no strobe is active.
- R10: A strobe lasts one clock and at most one strobe is active at a time. Strobes and register updates appear on the third rising `clk` edge after the eighth `sclk` rise reaches the pins.
- R11: Opcodes 110 and 111 are ignored. Data bytes that follow a register or ignored opcode produce no strobe and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, LSB first |
| charWe | output | 1 | Character RAM write strobe |
| patWe | output | 1 | Pattern RAM write strobe |
| auxWe | output | 1 | Auxiliary RAM write strobe |
| ramAddr | output | 5 | Write address for the active strobe |
| ramData | output | 8 | Write data for the active strobe |
| digitCount | output | 5 | Number of display digits, 1 to 16 |
| brightness | output | 5 | Brightness level, 0 to 16 sixteenths |
| lightsMode | output | 2 | All-lights mode: 0 normal, 1 all lit, 2 all dark |

## Verification
Every result is due on the third clock edge after a shift-clock rise reaches the pins: two edges through the synchroniser and one edge for detection and the output register. The bench drives inputs on falling clock edges and holds each shift-clock level for four clocks, so each result has settled before the next bit. Strobes are logged on falling edges and compared once the window closes. A directed test samples a register at two and at three edges after the final rise, which pins the latency down exactly.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;
  localparam int WORD_W = 8;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_CHAR   = 3'd0;
  localparam logic [OP_W-1:0] OP_PAT    = 3'd1;
  localparam logic [OP_W-1:0] OP_AUX    = 3'd2;
  localparam logic [OP_W-1:0] OP_DIGITS = 3'd3;
  localparam logic [OP_W-1:0] OP_BRIGHT = 3'd4;
  localparam logic [OP_W-1:0] OP_LIGHTS = 3'd5;

  typedef struct packed {
    logic shiftEn;
    logic cmdLoad;
    logic dataLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/disp_cmd_control.sv
module disp_cmd_control
  import disp_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        selActive,
  input  logic        sclkRise,
  output ctrlStrobe_t strobe
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             firstByte;
  logic             take;
  logic             wordDone;

  assign take     = selActive & sclkRise;
  assign wordDone = take & (bitCnt == LAST_BIT);

  always_comb begin
    strobe.shiftEn  = take;
    strobe.cmdLoad  = wordDone & firstByte;
    strobe.dataLoad = wordDone & ~firstByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      firstByte <= 1'b1;
    end else if (!selActive) begin
      bitCnt    <= '0;
      firstByte <= 1'b1;
    end else if (take) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT) firstByte <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_cmd_datapath.sv
module disp_cmd_datapath
  import disp_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5,
  parameter int CHAR_DEPTH  = 16,
  parameter int PAT_DEPTH   = 32,
  parameter int AUX_DEPTH   = 16,
  parameter int MAX_DIGITS  = 16,
  parameter int MAX_BRIGHT  = 16,
  parameter int LEVEL_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              sclk,
  input  logic              sdata,
  input  ctrlStrobe_t       strobe,
  output logic              selActive,
  output logic              sclkRise,
  output logic              charWe,
  output logic              patWe,
  output logic              auxWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [WORD_W-1:0] ramData,
  output logic [LEVEL_W-1:0] digitCount,
  output logic [LEVEL_W-1:0] brightness,
  output logic [1:0]        lightsMode
);
  localparam logic [ADDR_W-1:0] CHAR_MASK = ADDR_W'(CHAR_DEPTH - 1);
  localparam logic [ADDR_W-1:0] PAT_MASK  = ADDR_W'(PAT_DEPTH - 1);
  localparam logic [ADDR_W-1:0] AUX_MASK  = ADDR_W'(AUX_DEPTH - 1);
  localparam logic [LEVEL_W-1:0] DIGITS_FULL = LEVEL_W'(MAX_DIGITS);
  localparam logic [LEVEL_W-1:0] BRIGHT_TOP  = LEVEL_W'(MAX_BRIGHT);

  logic [SYNC_STAGES-1:0] selSh, clkSh, datSh;
  logic                   clkPrev;
  logic                   datS;
  logic [WORD_W-1:0]      shReg, word;
  logic [OP_W-1:0]        opReg;
  logic [ADDR_W-1:0]      addrPtr;

  function automatic logic [ADDR_W-1:0] depthMask(input logic [OP_W-1:0] op);
    case (op)
      OP_CHAR: depthMask = CHAR_MASK;
      OP_PAT:  depthMask = PAT_MASK;
      OP_AUX:  depthMask = AUX_MASK;
      default: depthMask = '1;
    endcase
  endfunction

  assign selActive = ~selSh[SYNC_STAGES-1];
  assign sclkRise  = clkSh[SYNC_STAGES-1] & ~clkPrev;
  assign datS      = datSh[SYNC_STAGES-1];
  assign word      = {datS, shReg[WORD_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSh   <= '1;
      clkSh   <= '0;
      datSh   <= '0;
      clkPrev <= 1'b0;
    end else begin
      selSh   <= {selSh[SYNC_STAGES-2:0], selN};
      clkSh   <= {clkSh[SYNC_STAGES-2:0], sclk};
      datSh   <= {datSh[SYNC_STAGES-2:0], sdata};
      clkPrev <= clkSh[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (strobe.shiftEn) shReg <= word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg      <= '1;
      addrPtr    <= '0;
      charWe     <= 1'b0;
      patWe      <= 1'b0;
      auxWe      <= 1'b0;
      ramAddr    <= '0;
      ramData    <= '0;
      digitCount <= DIGITS_FULL;
      brightness <= '0;
      lightsMode <= 2'd0;
    end else begin
      charWe <= 1'b0;
      patWe  <= 1'b0;
      auxWe  <= 1'b0;
      if (strobe.cmdLoad) begin
        opReg   <= word[WORD_W-1 -: OP_W];
        addrPtr <= word[ADDR_W-1:0] & depthMask(word[WORD_W-1 -: OP_W]);
        case (word[WORD_W-1 -: OP_W])
          OP_DIGITS: digitCount <= (word[3:0] == 4'd0) ? DIGITS_FULL
                                                       : LEVEL_W'(word[3:0]);
          OP_BRIGHT: brightness <= (LEVEL_W'(word[4:0]) > BRIGHT_TOP) ? BRIGHT_TOP
                                                                      : LEVEL_W'(word[4:0]);
          OP_LIGHTS: lightsMode <= (word[1:0] == 2'd3) ? 2'd0 : word[1:0];
          default: ;
        endcase
      end else if (strobe.dataLoad &&
                   (opReg == OP_CHAR || opReg == OP_PAT || opReg == OP_AUX)) begin
        charWe  <= (opReg == OP_CHAR);
        patWe   <= (opReg == OP_PAT);
        auxWe   <= (opReg == OP_AUX);
        ramAddr <= addrPtr;
        ramData <= word;
        addrPtr <= (addrPtr + 1'b1) & depthMask(opReg);
      end
    end
  end
endmodule

// File: rtl/disp_cmd_receiver.sv
module disp_cmd_receiver
  import disp_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5,
  parameter int CHAR_DEPTH  = 16,
  parameter int PAT_DEPTH   = 32,
  parameter int AUX_DEPTH   = 16,
  parameter int MAX_DIGITS  = 16,
  parameter int MAX_BRIGHT  = 16,
  parameter int LEVEL_W     = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               selN,
  input  logic               sclk,
  input  logic               sdata,
  output logic               charWe,
  output logic               patWe,
  output logic               auxWe,
  output logic [ADDR_W-1:0]  ramAddr,
  output logic [7:0]         ramData,
  output logic [LEVEL_W-1:0] digitCount,
  output logic [LEVEL_W-1:0] brightness,
  output logic [1:0]         lightsMode
);
  ctrlStrobe_t strobe;
  logic        selActive;
  logic        sclkRise;

  disp_cmd_control ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .selActive(selActive),
    .sclkRise (sclkRise),
    .strobe   (strobe)
  );

  disp_cmd_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .CHAR_DEPTH(CHAR_DEPTH),
    .PAT_DEPTH(PAT_DEPTH), .AUX_DEPTH(AUX_DEPTH), .MAX_DIGITS(MAX_DIGITS),
    .MAX_BRIGHT(MAX_BRIGHT), .LEVEL_W(LEVEL_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .selN      (selN),
    .sclk      (sclk),
    .sdata     (sdata),
    .strobe    (strobe),
    .selActive (selActive),
    .sclkRise  (sclkRise),
    .charWe    (charWe),
    .patWe     (patWe),
    .auxWe     (auxWe),
    .ramAddr   (ramAddr),
    .ramData   (ramData),
    .digitCount(digitCount),
    .brightness(brightness),
    .lightsMode(lightsMode)
  );
endmodule

// File: rtl/disp_cmd_receiver_chk.sv
module disp_cmd_receiver_chk #(
  parameter int ADDR_W  = 5,
  parameter int LEVEL_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               charWe,
  input logic               patWe,
  input logic               auxWe,
  input logic [ADDR_W-1:0]  ramAddr,
  input logic [7:0]         ramData,
  input logic [LEVEL_W-1:0] digitCount,
  input logic [LEVEL_W-1:0] brightness,
  input logic [1:0]         lightsMode
);
  logic anyWe;
  assign anyWe = charWe | patWe | auxWe;

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({charWe, patWe, auxWe}));

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyWe |=> !anyWe);

  // R4
  addr_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({ramAddr, ramData}) |-> anyWe);

  // R6
  digit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (digitCount >= 1) && (digitCount <= 16));

  // R7
  bright_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    brightness <= 16);

  // R8
  lights_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    lightsMode != 2'd3);

  // R9
  reset_values_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (digitCount == 16 && brightness == 0 && lightsMode == 0 && !anyWe));
endmodule

bind disp_cmd_receiver disp_cmd_receiver_chk #(.ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) chk_i (
  .clk(clk), .rstN(rstN), .charWe(charWe), .patWe(patWe), .auxWe(auxWe),
  .ramAddr(ramAddr), .ramData(ramData), .digitCount(digitCount),
  .brightness(brightness), .lightsMode(lightsMode)
);

// File: tb/disp_cmd_receiver_tb_top.sv
module disp_cmd_receiver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam int NVEC = 5;
  // {command, first data byte, number of data bytes}
  localparam logic [19:0] VEC [NVEC] = '{
    {8'h03, 8'hA5, 4'd2},
    {8'h3E, 8'h10, 4'd3},
    {8'h4E, 8'h7F, 4'd3},
    {8'h1E, 8'hF0, 4'd3},
    {8'h00, 8'h01, 4'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1, sclk = 1'b1, sdata = 1'b0;
  logic charWe, patWe, auxWe;
  logic [4:0] ramAddr, digitCount, brightness;
  logic [7:0] ramData;
  logic [1:0] lightsMode;

  int checks = 0, failures = 0;
  int logCnt = 0;
  int logKind [64];
  int logAddr [64];
  int logData [64];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_cmd_receiver dut_i (
    .clk(clk), .rstN(rstN), .selN(selN), .sclk(sclk), .sdata(sdata),
    .charWe(charWe), .patWe(patWe), .auxWe(auxWe), .ramAddr(ramAddr),
    .ramData(ramData), .digitCount(digitCount), .brightness(brightness),
    .lightsMode(lightsMode)
  );

  always @(negedge clk) begin
    if (rstN && (charWe || patWe || auxWe) && logCnt < 64) begin
      logKind[logCnt] = charWe ? 1 : (patWe ? 2 : 3);
      logAddr[logCnt] = int'(ramAddr);
      logData[logCnt] = int'(ramData);
      logCnt = logCnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b0;
    repeat (HOLD) @(negedge clk);
    sclk = 1'b1;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  task automatic openSel();
    @(negedge clk); selN = 1'b0;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic closeSel();
    @(negedge clk); selN = 1'b1;
    repeat (HOLD + 2) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [7:0] c);
    openSel(); sendByte(c); closeSel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: values held during reset
    chk("R9 digitCount", int'(digitCount), 16);
    chk("R9 brightness", int'(brightness), 0);
    chk("R9 lightsMode", int'(lightsMode), 0);
    chk("R9 ramAddr", int'(ramAddr), 0);
    chk("R9 strobes", int'({charWe, patWe, auxWe}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R4 R5: table of RAM write windows
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c, d0;
      int n, mask, kind;
      c = VEC[v][19:12]; d0 = VEC[v][11:4]; n = int'(VEC[v][3:0]);
      kind = int'(c[7:5]) + 1;
      mask = (c[7:5] == 3'd1) ? 31 : 15;
      logCnt = 0;
      openSel(); sendByte(c);
      for (int i = 0; i < n; i++) sendByte(d0 + 8'(i));
      closeSel();
      chk("R4 write count", logCnt, n);
      for (int i = 0; i < n && i < logCnt; i++) begin
        chk("R3 RAM select", logKind[i], kind);
        chk("R5 wrapped address", logAddr[i], ((int'(c[4:0]) & mask) + i) & mask);
        chk("R1 LSB-first data", logData[i], int'(8'(d0 + 8'(i))));
      end
    end

    // R6
    sendCmd(8'h65); chk("R6 digits 5", int'(digitCount), 5);
    sendCmd(8'h60); chk("R6 digits 0 means 16", int'(digitCount), 16);
    // R7
    sendCmd(8'h8C); chk("R7 brightness 12", int'(brightness), 12);
    sendCmd(8'h9F); chk("R7 brightness capped", int'(brightness), 16);
    // R8
    sendCmd(8'hA1); chk("R8 all lit", int'(lightsMode), 1);
    sendCmd(8'hA2); chk("R8 all dark", int'(lightsMode), 2);
    sendCmd(8'hA3); chk("R8 code 3 to normal", int'(lightsMode), 0);

    // R11: ignored opcode and data after register command
    logCnt = 0;
    openSel(); sendByte(8'hC5); sendByte(8'h07); closeSel();
    openSel(); sendByte(8'h83); sendByte(8'h55); closeSel();
    chk("R11 no strobe", logCnt, 0);
    chk("R11 brightness after data", int'(brightness), 3);
    chk("R11 digits untouched", int'(digitCount), 16);
    chk("R11 lights untouched", int'(lightsMode), 0);

    // R2: partial word discarded, framing restarts, sclk with select high ignored
    logCnt = 0;
    openSel(); sendBit(1'b1); sendBit(1'b1); sendBit(1'b0); closeSel();
    sendByte(8'h8A);
    chk("R2 partial and deselected", logCnt, 0);
    chk("R2 brightness untouched", int'(brightness), 3);
    openSel(); sendByte(8'h05); sendByte(8'h33); closeSel();
    chk("R2 restart count", logCnt, 1);
    chk("R2 restart addr", logAddr[0], 5);
    chk("R2 restart data", logData[0], 8'h33);

    // R10: latency of three clock edges after the eighth rise
    openSel();
    for (int i = 0; i < 7; i++) sendBit(1'(8'h89 >> i));
    @(negedge clk); sdata = 1'b1; sclk = 1'b0;
    repeat (HOLD) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 not yet at edge 2", int'(brightness), 3);
    @(negedge clk);
    chk("R10 due at edge 3", int'(brightness), 9);
    closeSel();

    // R9: reset again mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R9 re-reset brightness", int'(brightness), 0);
    chk("R9 re-reset addr", int'(ramAddr), 0);
    rstN = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule